// File: doc/BRIEF.md
# Serial DAC Command Receiver

This block is the digital front end of a single-channel 16-bit voltage DAC. A host writes to it over a three-wire, write-only serial link: an active-low frame select, a serial clock and a serial data line. The block brings all three lines into the system clock domain through two-flop synchronizers and finds their edges there. During an open frame it samples one data bit on every falling serial-clock edge and builds a 24-bit command. The command holds a 2-bit operating-mode field and a 16-bit conversion code.

Both fields are committed to their holding registers together, and only when the 24th bit arrives. A frame that the host closes early is dropped. Extra clock edges after a finished frame are ignored until frame select goes high and then falls again. The mode register drives four decoded outputs that control the analog stage: a power-down flag and three output-termination selects. The code register keeps its value in every power-down mode. A build parameter picks the code loaded at reset, either zero or half scale. A one-cycle strobe marks each commit.

Top module: `sdac_cmd_rx`

## Requirements
- R1: The command is 24 bits long and arrives most significant bit first. A bit is taken on each falling edge of the serial clock, and only while frame select is low and the frame has not yet reached 24 bits.
- R2: Command bits 23:18 are ignored. Bits 17:16 form the mode field and bits 15:0 form the conversion code.
- R3: On the 24th falling edge of a frame, the code and the mode are both committed at once. The new values appear on dac_code_o and mode_o within a few system clock cycles.
- R4: If frame select goes high before the 24th falling edge, the frame is discarded. Neither the code nor the mode changes, and no strobe is issued.
- R5: Mode decoding works as follows. Mode 00 is normal operation, with every select low. Mode 01 sets pwr_dn_o and term_1k_o. Mode 10 sets pwr_dn_o and term_100k_o. Mode 11 sets pwr_dn_o and term_hiz_o. At most one termination select is high at any time.
- R6: A power-down mode does not clear or alter the code register. dac_code_o keeps showing the last committed code.
- R7: After reset, mode_o is 00. dac_code_o is 0x0000 when MID_RESET is 0, or 0x8000 when MID_RESET is 1. These values hold until the first complete frame.
- R8: After a completed frame, further clock edges with frame select still low are ignored and cause no second commit. A new frame starts only on the next falling edge of frame select.
- R9: upd_o is high for exactly one system clock cycle for each committed frame, and never at any other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; must run at least four times faster than sclk_i |
| rst_n | input | 1 | Asynchronous active-low reset |
| fs_n_i | input | 1 | Frame select, active low |
| sclk_i | input | 1 | Serial clock; data is taken on its falling edge |
| sdata_i | input | 1 | Serial data, most significant bit first |
| dac_code_o | output | 16 | Committed conversion code |
| mode_o | output | 2 | Committed operating mode |
| pwr_dn_o | output | 1 | High in any power-down mode |
| term_1k_o | output | 1 | Power-down output tied low through the low-value load |
| term_100k_o | output | 1 | Power-down output tied low through the high-value load |
| term_hiz_o | output | 1 | Power-down output left floating |
| upd_o | output | 1 | One-cycle commit strobe |

## Verification
The assertions assume that the serial clock runs well below a quarter of the system clock rate. They also assume that serial data is stable around each falling serial-clock edge, so that the synchronized data and clock move together and no edge is lost. The bench keeps to both limits. Its serial clock phases each last four system cycles, data changes only while the serial clock is high, and frame select moves only while the serial clock is high. Within those limits the random frames mix full commits, early aborts of any length, and frames left open with extra clock edges.

// File: rtl/sdac_rx_pkg.sv
package sdac_rx_pkg;
  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_RUN     = 2'b00,
    MODE_PD_1K   = 2'b01,
    MODE_PD_100K = 2'b10,
    MODE_PD_HIZ  = 2'b11
  } pd_mode_e;

  typedef struct packed {
    logic pwr_dn;
    logic t_low;
    logic t_high;
    logic t_hiz;
  } term_sel_t;
endpackage

// File: rtl/sdac_rx_sync.sv
module sdac_rx_sync #(
  parameter int            W       = 3,
  parameter int            STAGES  = 2,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= RST_VAL;
        else        stg[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= RST_VAL;
        else        stg[s] <= stg[s-1];
      end
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/sdac_rx_shift.sv
module sdac_rx_shift #(
  parameter int FRAME_W = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fs_n_s,
  input  logic               sclk_s,
  input  logic               sdat_s,
  output logic               frm_done_o,
  output logic [FRAME_W-1:0] frm_word_o
);
  localparam int CNT_W = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  logic               fs_d, sclk_d;
  logic               armed_q, armed_n;
  logic [CNT_W-1:0]   cnt_q, cnt_n;
  logic [FRAME_W-1:0] sh_q, sh_n;
  logic               done_q, done_n;
  logic [FRAME_W-1:0] word_q;
  logic               fs_fall, sclk_fall;

  assign fs_fall   = fs_d & ~fs_n_s;
  assign sclk_fall = sclk_d & ~sclk_s;

  always_comb begin
    armed_n = armed_q;
    cnt_n   = cnt_q;
    sh_n    = sh_q;
    done_n  = 1'b0;
    if (fs_n_s) begin
      armed_n = 1'b0;
      cnt_n   = '0;
      sh_n    = '0;
    end else if (fs_fall) begin
      armed_n = 1'b1;
      cnt_n   = '0;
      sh_n    = '0;
    end else if (armed_q && sclk_fall) begin
      sh_n = {sh_q[FRAME_W-2:0], sdat_s};
      if (cnt_q == LAST) begin
        armed_n = 1'b0;
        cnt_n   = '0;
        done_n  = 1'b1;
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_d    <= 1'b1;
      sclk_d  <= 1'b1;
      armed_q <= 1'b0;
      cnt_q   <= '0;
      sh_q    <= '0;
      done_q  <= 1'b0;
    end else begin
      fs_d    <= fs_n_s;
      sclk_d  <= sclk_s;
      armed_q <= armed_n;
      cnt_q   <= cnt_n;
      sh_q    <= sh_n;
      done_q  <= done_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      word_q <= '0;
    else if (done_n) word_q <= sh_n;
  end

  assign frm_done_o = done_q;
  assign frm_word_o = word_q;
endmodule

// File: rtl/sdac_rx_regs.sv
module sdac_rx_regs
  import sdac_rx_pkg::*;
#(
  parameter int CODE_W    = 16,
  parameter int FRAME_W   = 24,
  parameter bit MID_RESET = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frm_done_i,
  input  logic [FRAME_W-1:0] frm_word_i,
  output logic [CODE_W-1:0]  code_o,
  output logic [MODE_W-1:0]  mode_o,
  output term_sel_t          sel_o,
  output logic               upd_o
);
  logic [CODE_W-1:0] rst_code;

  if (MID_RESET) begin : g_mid
    assign rst_code = {1'b1, {(CODE_W-1){1'b0}}};
  end else begin : g_zero
    assign rst_code = '0;
  end

  logic [CODE_W-1:0] code_q;
  pd_mode_e          mode_q;
  logic              upd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= rst_code;
      mode_q <= MODE_RUN;
    end else if (frm_done_i) begin
      code_q <= frm_word_i[CODE_W-1:0];
      mode_q <= pd_mode_e'(frm_word_i[CODE_W +: MODE_W]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) upd_q <= 1'b0;
    else        upd_q <= frm_done_i;
  end

  always_comb begin
    sel_o = '0;
    unique case (mode_q)
      MODE_PD_1K:   begin sel_o.pwr_dn = 1'b1; sel_o.t_low  = 1'b1; end
      MODE_PD_100K: begin sel_o.pwr_dn = 1'b1; sel_o.t_high = 1'b1; end
      MODE_PD_HIZ:  begin sel_o.pwr_dn = 1'b1; sel_o.t_hiz  = 1'b1; end
      default:      sel_o = '0;
    endcase
  end

  assign code_o = code_q;
  assign mode_o = mode_q;
  assign upd_o  = upd_q;
endmodule

// File: rtl/sdac_cmd_rx.sv
module sdac_cmd_rx
  import sdac_rx_pkg::*;
#(
  parameter int CODE_W      = 16,
  parameter int PAD_W       = 6,
  parameter int SYNC_STAGES = 2,
  parameter bit MID_RESET   = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fs_n_i,
  input  logic              sclk_i,
  input  logic              sdata_i,
  output logic [CODE_W-1:0] dac_code_o,
  output logic [1:0]        mode_o,
  output logic              pwr_dn_o,
  output logic              term_1k_o,
  output logic              term_100k_o,
  output logic              term_hiz_o,
  output logic              upd_o
);
  localparam int FRAME_W = PAD_W + MODE_W + CODE_W;

  logic [2:0]         sync_q;
  logic               fs_act;
  logic               frm_done;
  logic [FRAME_W-1:0] frm_word;
  term_sel_t          sel;

  sdac_rx_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({fs_n_i, sclk_i, sdata_i}),
    .q_o   (sync_q)
  );

  assign fs_act = ~sync_q[2];

  sdac_rx_shift #(.FRAME_W(FRAME_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .fs_n_s     (sync_q[2]),
    .sclk_s     (sync_q[1]),
    .sdat_s     (sync_q[0]),
    .frm_done_o (frm_done),
    .frm_word_o (frm_word)
  );

  sdac_rx_regs #(.CODE_W(CODE_W), .FRAME_W(FRAME_W), .MID_RESET(MID_RESET)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .frm_done_i (frm_done),
    .frm_word_i (frm_word),
    .code_o     (dac_code_o),
    .mode_o     (mode_o),
    .sel_o      (sel),
    .upd_o      (upd_o)
  );

  assign pwr_dn_o    = sel.pwr_dn;
  assign term_1k_o   = sel.t_low;
  assign term_100k_o = sel.t_high;
  assign term_hiz_o  = sel.t_hiz;
endmodule

// File: rtl/sdac_cmd_rx_chk.sv
module sdac_cmd_rx_chk #(
  parameter int CODE_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fs_act,
  input logic              frm_done,
  input logic [CODE_W-1:0] dac_code_o,
  input logic [1:0]        mode_o,
  input logic              pwr_dn_o,
  input logic              term_1k_o,
  input logic              term_100k_o,
  input logic              term_hiz_o,
  input logic              upd_o
);
  AST_CODE_ONLY_ON_UPD: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_code_o != $past(dac_code_o)) |-> upd_o); // R3
  AST_MODE_ONLY_ON_UPD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o != $past(mode_o)) |-> upd_o); // R4
  AST_DONE_INSIDE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    frm_done |-> $past(fs_act)); // R4
  AST_DONE_GIVES_UPD: assert property (@(posedge clk) disable iff (!rst_n)
    frm_done |=> upd_o); // R9
  AST_UPD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    upd_o |=> !upd_o); // R9
  AST_NO_DOUBLE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    frm_done |=> !frm_done); // R8
  AST_PD_ONE_TERM: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn_o |-> ($countones({term_1k_o, term_100k_o, term_hiz_o}) == 1)); // R5
  AST_RUN_NO_TERM: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_dn_o |-> ({term_1k_o, term_100k_o, term_hiz_o} == 3'b000)); // R5
endmodule

bind sdac_cmd_rx sdac_cmd_rx_chk #(.CODE_W(CODE_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .fs_act      (fs_act),
  .frm_done    (frm_done),
  .dac_code_o  (dac_code_o),
  .mode_o      (mode_o),
  .pwr_dn_o    (pwr_dn_o),
  .term_1k_o   (term_1k_o),
  .term_100k_o (term_100k_o),
  .term_hiz_o  (term_hiz_o),
  .upd_o       (upd_o)
);

// File: tb/sdac_cmd_rx_tb.sv
`timescale 1ns/1ps
module sdac_cmd_rx_tb_top;
  localparam int H = 4;

  logic clk, rst_n, fs_n, sclk, sdata;
  logic [15:0] code, code_mid;
  logic [1:0]  mode, mode_mid;
  logic pd, t1k, t100k, thz, upd;
  logic pd_m, t1k_m, t100k_m, thz_m, upd_m;

  int checks = 0, failures = 0, upd_cnt = 0, exp_upd = 0;
  logic [15:0] exp_code;
  logic [1:0]  exp_mode;
  bit finished = 0;

  sdac_cmd_rx dut_i (
    .clk(clk), .rst_n(rst_n), .fs_n_i(fs_n), .sclk_i(sclk), .sdata_i(sdata),
    .dac_code_o(code), .mode_o(mode), .pwr_dn_o(pd), .term_1k_o(t1k),
    .term_100k_o(t100k), .term_hiz_o(thz), .upd_o(upd));

  sdac_cmd_rx #(.MID_RESET(1'b1)) dut_mid_i (
    .clk(clk), .rst_n(rst_n), .fs_n_i(fs_n), .sclk_i(sclk), .sdata_i(sdata),
    .dac_code_o(code_mid), .mode_o(mode_mid), .pwr_dn_o(pd_m), .term_1k_o(t1k_m),
    .term_100k_o(t100k_m), .term_hiz_o(thz_m), .upd_o(upd_m));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) if (rst_n && upd) upd_cnt++;

  function automatic logic [3:0] exp_sel(input logic [1:0] m);
    case (m)
      2'b01:   return 4'b1100;
      2'b10:   return 4'b1010;
      2'b11:   return 4'b1001;
      default: return 4'b0000;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clocks(input logic [23:0] w, input int first, input int n);
    for (int i = 0; i < n; i++) begin
      sdata = w[23 - ((first + i) % 24)];
      sclk = 1'b1; cyc(H);
      sclk = 1'b0; cyc(H);
    end
    sclk = 1'b1; cyc(H);
  endtask

  task automatic send(input logic [23:0] w, input int edges, input bit keep_low);
    fs_n = 1'b1; cyc(2*H);
    fs_n = 1'b0; cyc(H);
    clocks(w, 0, edges);
    if (!keep_low) fs_n = 1'b1;
    cyc(3*H);
    if (edges >= 24) begin
      exp_code = w[15:0];
      exp_mode = w[17:16];
      exp_upd++;
    end
  endtask

  task automatic check_state(input string req);
    chk({req, " code"}, 32'(code), 32'(exp_code));
    chk({req, " mode"}, 32'(mode), 32'(exp_mode));
    chk({req, " sel"}, 32'({pd, t1k, t100k, thz}), 32'(exp_sel(exp_mode)));
    chk({req, " strobes"}, 32'(upd_cnt), 32'(exp_upd));
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    logic [23:0] w;
    int kind, n;
    void'($urandom(32'd20240611));
    fs_n = 1'b1; sclk = 1'b1; sdata = 1'b0; rst_n = 1'b0;
    exp_code = 16'h0000; exp_mode = 2'b00;
    cyc(5); rst_n = 1'b1; cyc(5);

    // R7 reset values, both parameter variants
    check_state("R7");
    chk("R7 mid code", 32'(code_mid), 32'h8000);
    chk("R7 mid mode", 32'(mode_mid), 32'h0);

    // R4 abort at 23 edges, also keeps mid-reset variant at 0x8000 (R7)
    send(24'hFFFFFF, 23, 1'b0);
    check_state("R4 abort23");
    chk("R7 mid hold", 32'(code_mid), 32'h8000);
    send(24'h0, 0, 1'b0);
    check_state("R4 abort0");

    // R1 R2 full frame, pad bits set
    send({6'h3F, 2'b00, 16'hA5C3}, 24, 1'b0);
    check_state("R1 R2 R3 run");
    chk("R9 mid strobe code", 32'(code_mid), 32'hA5C3);

    // R5 each mode; R6 code kept in power-down
    send({6'h00, 2'b01, 16'h1234}, 24, 1'b0);
    check_state("R5 R6 pd1k");
    send({6'h15, 2'b10, 16'hFFFF}, 24, 1'b0);
    check_state("R5 R6 pd100k");
    send({6'h2A, 2'b11, 16'h0001}, 24, 1'b0);
    check_state("R5 R6 hiz");
    send({6'h00, 2'b11, 16'h0001}, 20, 1'b0);
    check_state("R4 abort in pd");

    // R8 frame left open, extra edges ignored
    w = {6'h00, 2'b00, 16'h7FFF};
    send(w, 24, 1'b1);
    clocks(24'h00FFFF ^ 24'h3C3C3C, 0, 12);
    cyc(3*H);
    check_state("R8 extra edges");
    fs_n = 1'b1; cyc(2*H);
    send({6'h01, 2'b00, 16'h8000}, 24, 1'b0);
    check_state("R8 new frame");

    // random mix
    for (int it = 0; it < 50; it++) begin
      w = 24'($urandom);
      kind = int'($urandom % 4);
      if (kind == 0) begin
        n = int'($urandom % 24);
        send(w, n, 1'b0);
        check_state("R4 rnd abort");
      end else if (kind == 1) begin
        send(w, 24, 1'b1);
        clocks(24'($urandom), 0, 1 + int'($urandom % 30));
        cyc(3*H);
        check_state("R8 rnd open");
      end else begin
        send(w, 24, 1'b0);
        check_state("R3 R9 rnd");
      end
    end

    finished = 1;
    summary();
    $finish;
  end
endmodule